// File: doc/BRIEF.md
# I2C Write-Only Clock-Control Register Slave

This block is the programming port of a clock generator. It sits on a two-wire serial bus as a slave that only accepts writes. It answers a single fixed device address. After the address it takes a command byte and a count byte, acknowledges both and discards their values. Every byte after those two is stored in a bank of configuration registers, starting at register 0 and moving up by one for each byte. There is no way to read the registers back and no way to choose a start register. To change a later register, the host has to resend every register below it.

The register bank drives parallel outputs. Register 0 is decoded into a spread-width flag, a three-bit software frequency select, a hardware/software select flag and a two-bit output mode. All registers, including the per-output enable registers, also appear on a flat configuration bus. SCL and SDA are brought into the block's system clock through two-flop synchronisers. START, STOP and clock edges are found from the synchronised samples. The block drives SDA only in one way: it pulls the line low to acknowledge. Register contents survive STOP and later transactions. Only the reset input reloads the defaults. There is no data stream at the block's edge, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The only address byte acknowledged is 0xD2, which is device address 0x69 with a write bit of 0. Any other first byte gets no acknowledge, and this includes 0xD3, a read. In that case no later byte of the same transaction is acknowledged or stored.
- R2: Bytes are shifted in MSB first. For each accepted byte the slave holds SDA low through the ninth SCL clock. The pull is applied and released only while SCL is low.
- R3: A START, whether or not a STOP came first, restarts byte counting, so the next data byte goes to register 0 again. After a STOP the slave does not pull SDA.
- R4: The two bytes after the address (command, then count) are acknowledged, and their values leave every register unchanged.
- R5: Data byte n (counting from 0) of a transaction is written to register n, which appears on cfg_o bits [8n+7:8n].
- R6: At most NREG data bytes (default 10) are accepted per transaction. Later data bytes are not acknowledged and change no register.
- R7: Register values hold across STOP and across later transactions. A short transaction leaves the registers above its last data byte unchanged.
- R8: Reset loads register 0 with 0xF4 and every other register with 0xFF. Nothing else reloads these values.
- R9: Register 0 is decoded as follows:
  - spread_narrow_o = bit 7 (1 narrow, 0 wide)
  - freq_sel_o = bits 6:4
  - sw_freq_o = bit 3 (1 software select, 0 hardware select)
  - mode_o = bits 1:0 (11 tri-state, 10 normal with spread, 01 test, 00 normal without spread)
- R10: cfg_o changes only in the cycle after an accepted data byte is committed. The commit happens on the SCL falling edge that ends that byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset; loads the register defaults |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| cfg_o | output | NREG*8 | All registers, with register n at bits [8n+7:8n] |
| spread_narrow_o | output | 1 | Spread width select from register 0 |
| freq_sel_o | output | 3 | Software frequency select from register 0 |
| sw_freq_o | output | 1 | 1 = software frequency select in force |
| mode_o | output | 2 | Output mode from register 0 |

## Verification
The bound checker checks the acknowledge timing on every cycle:
- The SDA pull rises and falls only while SCL is low.
- START and STOP both release the pull at once.
- The register bus never moves without a committed write.

Address filtering, the discarding of the command and count bytes, the ten-byte limit, pointer restart on a repeated START and persistence across transactions all depend on the byte history. Only the bench's transaction scenarios can show these. The bench checks them against a behavioural register model that it compares with the outputs on every clock.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  // Bytes that precede register data: address, command, count
  localparam int HDR_BYTES = 3;

  typedef enum logic [1:0] {
    PH_IDLE,   // bus free or transfer ended
    PH_SHIFT,  // collecting bits of a byte
    PH_ACK,    // holding SDA low through the ninth clock
    PH_SKIP    // not addressed or past the limit: wait for START/STOP
  } phase_e;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'hF4 : 8'hFF;
  endfunction
endpackage

// File: rtl/clkcfg_i2c_sync.sv
module clkcfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkcfg_i2c_engine.sv
module clkcfg_i2c_engine
  import clkcfg_pkg::*;
#(
  parameter int         NREG     = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int IDXW = $clog2(NREG + HDR_BYTES + 1),
  localparam int PTRW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  output logic            sda_pull,
  output logic            wr_en,
  output logic [PTRW-1:0] wr_idx,
  output logic [7:0]      wr_data
);
  localparam logic [IDXW-1:0] HDR_I  = IDXW'(HDR_BYTES);
  localparam logic [IDXW-1:0] NREG_I = IDXW'(NREG);
  localparam logic [7:0]      ADDR_W = {DEV_ADDR, 1'b0};

  phase_e          phase;
  logic [7:0]      shreg;
  logic [3:0]      bitc;
  logic [IDXW-1:0] bidx;
  logic [IDXW-1:0] dptr;
  logic            is_data, accept;

  // Acceptance decision for the byte now complete in shreg
  always_comb begin
    dptr    = bidx - HDR_I;
    is_data = (bidx >= HDR_I);
    if (bidx == '0)   accept = (shreg == ADDR_W);
    else if (!is_data) accept = 1'b1;
    else              accept = (dptr < NREG_I);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      shreg   <= '0;
      bitc    <= '0;
      bidx    <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        phase <= PH_SHIFT;
        bitc  <= '0;
        bidx  <= '0;
      end else if (stop_evt) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_SHIFT: begin
            if (scl_rise && bitc < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              bitc  <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc <= '0;
              if (accept) begin
                phase <= PH_ACK;
                bidx  <= bidx + 1'b1;
                if (is_data) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= dptr[PTRW-1:0];
                  wr_data <= shreg;
                end
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_ACK:  if (scl_fall) phase <= PH_SHIFT;
          PH_IDLE, PH_SKIP: ;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign sda_pull = (phase == PH_ACK);
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int NREG = 10,
  localparam int PTRW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTRW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] cfg
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              val <= reg_default(i);
      else if (wr_en && wr_idx == PTRW'(i))    val <= wr_data;
    end
    assign cfg[i*8 +: 8] = val;
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter int         NREG        = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2,
  localparam int PTRW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic              spread_narrow_o,
  output logic [2:0]        freq_sel_o,
  output logic              sw_freq_o,
  output logic [1:0]        mode_o
);
  logic            sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic            wr_en;
  logic [PTRW-1:0] wr_idx;
  logic [7:0]      wr_data;

  clkcfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  clkcfg_i2c_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkcfg_regbank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg(cfg_o)
  );

  assign spread_narrow_o = cfg_o[7];
  assign freq_sel_o      = cfg_o[6:4];
  assign sw_freq_o       = cfg_o[3];
  assign mode_o          = cfg_o[1:0];
endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk #(
  parameter int W = 80
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_i,
  input logic         sda_pull_o,
  input logic         start_evt,
  input logic         stop_evt,
  input logic         wr_en,
  input logic [W-1:0] cfg_o
);
  // R2
  ack_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);
  // R2
  ack_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_i);
  // R3
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull_o);
  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o);
  // R10
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o != $past(cfg_o)) |-> $past(wr_en));
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_chk #(.W(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .start_evt(start_evt), .stop_evt(stop_evt), .wr_en(wr_en), .cfg_o(cfg_o)
);

// File: tb/clkcfg_i2c_slave_test.sv
module clkcfg_i2c_slave_test;
  localparam int NREG = 10;
  localparam int Q    = 8;   // system clocks per SCL half-phase step

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_i, sda_i, sda_pull_o;
  logic [NREG*8-1:0] cfg_o;
  logic spread_narrow_o, sw_freq_o;
  logic [2:0] freq_sel_o;
  logic [1:0] mode_o;

  int total = 0, bad = 0;
  bit done = 1'b0, cmp_on = 1'b0, pend = 1'b0;
  logic [NREG*8-1:0] exp_flat, pend_flat;

  always #4 clk = ~clk;

  assign scl_i = m_scl;
  assign sda_i = m_sda & ~sda_pull_o;   // open-drain wired AND

  clkcfg_i2c_slave #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_pull_o(sda_pull_o), .cfg_o(cfg_o), .spread_narrow_o(spread_narrow_o),
    .freq_sel_o(freq_sel_o), .sw_freq_o(sw_freq_o), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural model (R10, R9)
  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk(cfg_o == exp_flat || (pend && cfg_o == pend_flat), "R10", cfg_o, exp_flat);
      if (!pend)
        chk({spread_narrow_o, freq_sel_o, sw_freq_o, mode_o} ==
            {exp_flat[7], exp_flat[6:4], exp_flat[3], exp_flat[1:0]}, "R9",
            {spread_narrow_o, freq_sel_o, sw_freq_o, mode_o},
            {exp_flat[7], exp_flat[6:4], exp_flat[3], exp_flat[1:0]});
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_sda = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int slot, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold(Q);
      m_scl = 1'b1; hold(Q);
      if (i == 0 && slot >= 0) begin
        pend_flat = exp_flat;
        pend_flat[slot*8 +: 8] = b;
        pend = 1'b1;
      end
      m_scl = 1'b0; hold(Q);
    end
    m_sda = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q/2);
    acked = (sda_i == 1'b0);
    hold(Q/2);
    m_scl = 1'b0; hold(Q);
    if (pend) begin
      exp_flat = pend_flat;
      pend = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] q[$], input bit with_stop);
    bit addr_ok, got, exp_ack;
    int slot;
    string tag;
    i2c_start();
    addr_ok = (q[0] == 8'hD2);
    foreach (q[k]) begin
      exp_ack = (k == 0) ? addr_ok : (addr_ok && (k < 3 || k - 3 < NREG));
      slot = (exp_ack && k >= 3) ? k - 3 : -1;
      if (!addr_ok || k == 0) tag = "R1";
      else if (k < 3)         tag = "R4";
      else if (k - 3 >= NREG) tag = "R6";
      else                    tag = "R2";
      send_byte(q[k], slot, got);
      chk(got == exp_ack, tag, {79'd0, got}, {79'd0, exp_ack});
      chk(cfg_o == exp_flat, (k >= 3) ? "R5" : "R4", cfg_o, exp_flat);
    end
    if (with_stop) begin
      i2c_stop();
      hold(Q);
      chk(sda_pull_o == 1'b0, "R3", {79'd0, sda_pull_o}, 80'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    exp_flat = 80'hFFFF_FFFF_FFFF_FFFF_FFF4;
    pend_flat = exp_flat;
    hold(5);
    rst_n = 1'b1;
    hold(2);
    // R8: defaults after reset
    chk(cfg_o == exp_flat, "R8", cfg_o, exp_flat);
    // R9: decoded defaults: narrow, S=7, hardware select, mode 00
    chk({spread_narrow_o, freq_sel_o, sw_freq_o, mode_o} == 7'b1_111_0_00, "R9",
        {73'd0, spread_narrow_o, freq_sel_o, sw_freq_o, mode_o}, {73'd0, 7'b1111000});
    cmp_on = 1'b1;

    // R5/R4: ignored command 0x05 and count 0x01, then 4 data bytes
    q = '{8'hD2, 8'h05, 8'h01, 8'h3A, 8'h01, 8'h80, 8'h5C};
    txn(q, 1'b1);
    // R9: register 0 = 0x3A -> wide, S=3, software, mode 10
    chk({spread_narrow_o, freq_sel_o, sw_freq_o, mode_o} == 7'b0_011_1_10, "R9",
        {73'd0, spread_narrow_o, freq_sel_o, sw_freq_o, mode_o}, {73'd0, 7'b0011110});
    // R2: 0x01 vs 0x80 land without bit reversal
    chk(cfg_o[15:8] == 8'h01 && cfg_o[23:16] == 8'h80, "R2",
        {64'd0, cfg_o[23:8]}, {64'd0, 16'h8001});

    // R6: ten data bytes plus an eleventh that must be refused
    q = '{8'hD2, 8'h00, 8'h0B, 8'h13, 8'h21, 8'h32, 8'h43, 8'h54,
          8'h65, 8'h76, 8'h87, 8'h98, 8'hA9, 8'hEE};
    txn(q, 1'b1);
    chk(cfg_o == 80'hA998_8776_6554_4332_2113, "R6", cfg_o, 80'hA998_8776_6554_4332_2113);

    // R1: wrong address, then read address, both ignored entirely
    q = '{8'hD0, 8'h00, 8'h00, 8'h00};
    txn(q, 1'b1);
    q = '{8'hD3, 8'h00, 8'h00, 8'hFF};
    txn(q, 1'b1);
    chk(cfg_o == 80'hA998_8776_6554_4332_2113, "R1", cfg_o, 80'hA998_8776_6554_4332_2113);

    // R7: short write touches only register 0 and 1
    q = '{8'hD2, 8'hFF, 8'hFF, 8'h00, 8'h7E};
    txn(q, 1'b1);
    hold(40);
    chk(cfg_o == 80'hA998_8776_6554_4332_7E00, "R7", cfg_o, 80'hA998_8776_6554_4332_7E00);

    // R3: repeated START without STOP restarts at register 0
    q = '{8'hD2, 8'h00, 8'h00, 8'h11, 8'h22};
    txn(q, 1'b0);
    q = '{8'hD2, 8'h00, 8'h00, 8'h9F};
    txn(q, 1'b1);
    chk(cfg_o == 80'hA998_8776_6554_4332_229F, "R3", cfg_o, 80'hA998_8776_6554_4332_229F);

    hold(20);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule